// File: doc/BRIEF.md
# Classic-Cycle Bus Register Slice

This block is a register stage placed in the middle of a classic single-access memory-mapped bus so that long timing paths can be broken. On its upstream side it acts as a target for a bus master. On its downstream side it acts as an initiator toward a bus target. Cycle, strobe, address, write enable, byte selects and write data move downstream through flops. The acknowledge and the read data move back upstream through flops. Every path that crosses the block therefore starts or ends at a register. The upstream master still sees an acknowledge that is exactly one cycle wide.

The downstream target may register its acknowledge or drive it combinationally from the strobe. The slice works with both kinds. As soon as it samples the downstream acknowledge, it drops the downstream strobe. After it has sent an acknowledge upstream, it waits until the upstream strobe has been low for at least one sampled edge before it starts another downstream access. This stops a master that is slow to release its strobe from triggering a second, unintended access. A block transfer that keeps the cycle signal high and briefly drops the strobe between beats is forwarded beat by beat.

Top module: `wb_reg_slice`

## Requirements
- R1: The downstream cycle signal equals the upstream cycle signal delayed by one clock. The downstream strobe rises on the first edge at which the slice samples upstream cycle and strobe both high. From that cycle on, the downstream address, write enable, byte selects and write data hold the values sampled on that edge.
- R2: When the downstream target registers its acknowledge, the downstream strobe is high for exactly two cycles per access. When the target's acknowledge is combinational, the downstream strobe is high for exactly one cycle.
- R3: The downstream strobe falls on the edge at which the downstream acknowledge is sampled high.
- R4: The upstream acknowledge goes high in the cycle after the downstream acknowledge is sampled, and stays high for exactly one cycle.
- R5: Read data is captured on the edge at which the downstream acknowledge is sampled, and is driven upstream in the same cycle as the upstream acknowledge.
- R6: A master that drops its strobe on the first edge after it sees the acknowledge keeps the strobe high for four cycles with a registered-acknowledge target, and for three cycles with a combinational-acknowledge target.
- R7: After an upstream acknowledge, no new downstream strobe and no further upstream acknowledge occur while the upstream strobe stays high. A new access starts only after the upstream strobe has been sampled low.
- R8: A synchronous active-high reset clears the downstream cycle, the downstream strobe and the upstream acknowledge.
- R9: If the upstream cycle signal falls while a downstream access is waiting for its acknowledge, the downstream strobe and the downstream cycle signal fall on the next edge, and no upstream acknowledge is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| usCyc | input | 1 | Upstream bus cycle in progress |
| usStb | input | 1 | Upstream access strobe |
| usWe | input | 1 | Upstream write enable |
| usAdr | input | ADDR_W | Upstream address |
| usSel | input | DATA_W/8 | Upstream byte selects |
| usDatW | input | DATA_W | Upstream write data |
| usDatR | output | DATA_W | Read data returned to the master |
| usAck | output | 1 | One-cycle acknowledge to the master |
| dsCyc | output | 1 | Registered downstream cycle |
| dsStb | output | 1 | Registered downstream strobe |
| dsWe | output | 1 | Registered downstream write enable |
| dsAdr | output | ADDR_W | Registered downstream address |
| dsSel | output | DATA_W/8 | Registered downstream byte selects |
| dsDatW | output | DATA_W | Registered downstream write data |
| dsDatR | input | DATA_W | Read data from the downstream target |
| dsAck | input | 1 | Acknowledge from the downstream target |

## Verification
The assertions check several rules on every cycle: the one-cycle delay on the cycle signal, that the strobe drops right after a sampled acknowledge, that each upstream acknowledge is one cycle wide and is caused by a downstream acknowledge, that the read data matches the value sampled with that acknowledge, and that the strobe stays quiet in the cycle after an acknowledge. Some behaviour can only be shown by the bench's scenarios. These are the total strobe widths for each kind of target, the hold-off while a master keeps its strobe high after completion, the abandoned access when the cycle signal drops, and the clearing by reset in the middle of an access.

// File: rtl/wb_reg_slice_pkg.sv
package wb_reg_slice_pkg;

  // Strobes issued by the control FSM to the datapath registers.
  typedef struct packed {
    logic load;     // latch the upstream request fields
    logic capture;  // latch the downstream read data
  } sliceStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE,  // waiting for an upstream request
    ST_BUSY,  // downstream strobe asserted, waiting for acknowledge
    ST_RESP,  // upstream acknowledge being driven
    ST_HOLD   // waiting for the master to release its strobe
  } sliceState_t;

endpackage

// File: rtl/wb_reg_slice_ctrl.sv
module wb_reg_slice_ctrl
  import wb_reg_slice_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       usCyc,
  input  logic       usStb,
  input  logic       dsAck,
  output logic       dsCyc,
  output logic       dsStb,
  output logic       usAck,
  output sliceStrb_t strb
);

  sliceState_t state;

  logic request;
  logic ackSeen;

  assign request = usCyc && usStb;
  assign ackSeen = (state == ST_BUSY) && usCyc && dsAck;

  assign strb.load    = (state == ST_IDLE) && request;
  assign strb.capture = ackSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      dsCyc <= 1'b0;
      dsStb <= 1'b0;
      usAck <= 1'b0;
    end else begin
      dsCyc <= usCyc;
      usAck <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (request) begin
            state <= ST_BUSY;
            dsStb <= 1'b1;
          end
        end
        ST_BUSY: begin
          if (!usCyc) begin
            state <= ST_IDLE;
            dsStb <= 1'b0;
          end else if (dsAck) begin
            state <= ST_RESP;
            dsStb <= 1'b0;
            usAck <= 1'b1;
          end
        end
        ST_RESP: begin
          state <= usStb ? ST_HOLD : ST_IDLE;
        end
        ST_HOLD: begin
          if (!usStb) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wb_reg_slice_data.sv
module wb_reg_slice_data
  import wb_reg_slice_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  sliceStrb_t               strb,
  input  logic                     usWe,
  input  logic [ADDR_W-1:0]        usAdr,
  input  logic [(DATA_W/8)-1:0]    usSel,
  input  logic [DATA_W-1:0]        usDatW,
  input  logic [DATA_W-1:0]        dsDatR,
  output logic                     dsWe,
  output logic [ADDR_W-1:0]        dsAdr,
  output logic [(DATA_W/8)-1:0]    dsSel,
  output logic [DATA_W-1:0]        dsDatW,
  output logic [DATA_W-1:0]        usDatR
);

  localparam int LANES = DATA_W / 8;

  always_ff @(posedge clk) begin
    if (strb.load) begin
      dsWe  <= usWe;
      dsAdr <= usAdr;
      dsSel <= usSel;
    end
  end

  // One byte lane of write and read data per generate iteration.
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    always_ff @(posedge clk) begin
      if (strb.load)    dsDatW[lane*8 +: 8] <= usDatW[lane*8 +: 8];
      if (strb.capture) usDatR[lane*8 +: 8] <= dsDatR[lane*8 +: 8];
    end
  end

endmodule

// File: rtl/wb_reg_slice.sv
module wb_reg_slice
  import wb_reg_slice_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  usCyc,
  input  logic                  usStb,
  input  logic                  usWe,
  input  logic [ADDR_W-1:0]     usAdr,
  input  logic [(DATA_W/8)-1:0] usSel,
  input  logic [DATA_W-1:0]     usDatW,
  output logic [DATA_W-1:0]     usDatR,
  output logic                  usAck,
  output logic                  dsCyc,
  output logic                  dsStb,
  output logic                  dsWe,
  output logic [ADDR_W-1:0]     dsAdr,
  output logic [(DATA_W/8)-1:0] dsSel,
  output logic [DATA_W-1:0]     dsDatW,
  input  logic [DATA_W-1:0]     dsDatR,
  input  logic                  dsAck
);

  sliceStrb_t strb;

  wb_reg_slice_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .usCyc (usCyc),
    .usStb (usStb),
    .dsAck (dsAck),
    .dsCyc (dsCyc),
    .dsStb (dsStb),
    .usAck (usAck),
    .strb  (strb)
  );

  wb_reg_slice_data #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk    (clk),
    .strb   (strb),
    .usWe   (usWe),
    .usAdr  (usAdr),
    .usSel  (usSel),
    .usDatW (usDatW),
    .dsDatR (dsDatR),
    .dsWe   (dsWe),
    .dsAdr  (dsAdr),
    .dsSel  (dsSel),
    .dsDatW (dsDatW),
    .usDatR (usDatR)
  );

endmodule

// File: rtl/wb_reg_slice_chk.sv
module wb_reg_slice_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              usCyc,
  input logic              usAck,
  input logic [DATA_W-1:0] usDatR,
  input logic              dsCyc,
  input logic              dsStb,
  input logic              dsAck,
  input logic [DATA_W-1:0] dsDatR
);

  // R1: downstream cycle follows upstream cycle by one clock
  a_r1_cyc_rise: assert property (@(posedge clk) disable iff (rst)
    usCyc |=> dsCyc);
  a_r1_cyc_fall: assert property (@(posedge clk) disable iff (rst)
    !usCyc |=> !dsCyc);

  // R3: strobe drops once the acknowledge is sampled
  a_r3_stb_drop: assert property (@(posedge clk) disable iff (rst)
    (dsStb && dsAck) |=> !dsStb);

  // R4: upstream acknowledge is one cycle wide
  a_r4_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    usAck |=> !usAck);

  // R4: upstream acknowledge follows a sampled downstream acknowledge
  a_r4_ack_cause: assert property (@(posedge clk) disable iff (rst)
    (dsStb && dsAck && usCyc) |=> usAck);

  // R5: read data presented with acknowledge equals the captured value
  a_r5_rdata: assert property (@(posedge clk) disable iff (rst)
    $rose(usAck) |-> (usDatR == $past(dsDatR)));

  // R7: no downstream strobe in the cycle following an upstream acknowledge
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    usAck |=> !dsStb);

  // R9: strobe never outlives the cycle signal by more than one edge
  a_r9_abort: assert property (@(posedge clk) disable iff (rst)
    (!usCyc && dsStb) |=> !dsStb);

endmodule

bind wb_reg_slice wb_reg_slice_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .usCyc  (usCyc),
  .usAck  (usAck),
  .usDatR (usDatR),
  .dsCyc  (dsCyc),
  .dsStb  (dsStb),
  .dsAck  (dsAck),
  .dsDatR (dsDatR)
);

// File: tb/wb_reg_slice_tb.sv
`timescale 1ns/1ps
module wb_reg_slice_tb;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = DW / 8;
  localparam logic [DW-1:0] MAGIC = 32'h5A3C_0F96;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          usCyc = 1'b0, usStb = 1'b0, usWe = 1'b0;
  logic [AW-1:0] usAdr = '0;
  logic [SW-1:0] usSel = '0;
  logic [DW-1:0] usDatW = '0;
  logic [DW-1:0] usDatR;
  logic          usAck;
  logic          dsCyc, dsStb, dsWe;
  logic [AW-1:0] dsAdr;
  logic [SW-1:0] dsSel;
  logic [DW-1:0] dsDatW;
  logic [DW-1:0] dsDatR;
  logic          dsAck;

  // Target model: registered or combinational acknowledge
  logic          combMode = 1'b0;
  logic          noAck = 1'b0;
  logic          slvAckQ;
  logic [AW-1:0] recAdr;
  logic [SW-1:0] recSel;
  logic [DW-1:0] recDat;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  wb_reg_slice #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .usCyc(usCyc), .usStb(usStb), .usWe(usWe), .usAdr(usAdr),
    .usSel(usSel), .usDatW(usDatW), .usDatR(usDatR), .usAck(usAck),
    .dsCyc(dsCyc), .dsStb(dsStb), .dsWe(dsWe), .dsAdr(dsAdr),
    .dsSel(dsSel), .dsDatW(dsDatW), .dsDatR(dsDatR), .dsAck(dsAck)
  );

  always_ff @(posedge clk) begin
    if (rst) slvAckQ <= 1'b0;
    else     slvAckQ <= dsCyc && dsStb && !slvAckQ && !noAck && !combMode;
    if (dsAck && dsStb && dsWe) begin
      recAdr <= dsAdr;
      recSel <= dsSel;
      recDat <= dsDatW;
    end
  end

  assign dsAck  = combMode ? (dsCyc && dsStb && !noAck) : slvAckQ;
  assign dsDatR = dsAdr ^ MAGIC;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic          comb;
    logic          we;
    logic [AW-1:0] adr;
    logic [SW-1:0] sel;
    logic [DW-1:0] wdat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b1, 32'h0000_1000, 4'hF, 32'hDEAD_BEEF},
    '{1'b0, 1'b0, 32'h0000_1000, 4'hF, 32'h0000_0000},
    '{1'b1, 1'b1, 32'h0000_2004, 4'h3, 32'h1234_5678},
    '{1'b1, 1'b0, 32'hFFFF_FFFC, 4'hF, 32'h0000_0000},
    '{1'b0, 1'b1, 32'h8000_0008, 4'h8, 32'hA5A5_5A5A},
    '{1'b1, 1'b0, 32'h0000_0000, 4'h1, 32'h0000_0000}
  };

  // One access; holdCycles > 0 keeps the strobe high after the acknowledge.
  task automatic access(input vec_t v, input int holdCycles, input bit keepCyc);
    int cnt = 0;
    int dsCnt = 0;
    bit gotAck = 0;
    logic [DW-1:0] rd = '0;
    @(negedge clk);
    combMode = v.comb;
    usCyc = 1'b1; usStb = 1'b1; usWe = v.we;
    usAdr = v.adr; usSel = v.sel; usDatW = v.wdat;
    for (int i = 0; i < 16 && !gotAck; i++) begin
      @(negedge clk);
      cnt++;
      if (i == 0) begin
        check(dsStb && dsCyc, "R1 strobe/cycle launch", {dsStb, dsCyc}, 2'b11);
        check(dsAdr == v.adr && dsWe == v.we && dsSel == v.sel && dsDatW == v.wdat,
              "R1 request fields", dsAdr, v.adr);
      end
      if (dsStb) dsCnt++;
      if (usAck) begin
        gotAck = 1;
        rd = usDatR;
        check(!dsStb, "R3 strobe dropped at ack", dsStb, 0);
      end
    end
    check(gotAck, "R4 upstream ack seen", gotAck, 1);
    check(dsCnt == (v.comb ? 1 : 2), "R2 downstream strobe width", dsCnt, v.comb ? 1 : 2);
    if (!v.we) check(rd == (v.adr ^ MAGIC), "R5 read data", rd, v.adr ^ MAGIC);
    for (int h = 0; h < holdCycles; h++) begin
      @(negedge clk);
      check(!dsStb && !usAck, "R7 held strobe starts nothing", {dsStb, usAck}, 0);
    end
    @(negedge clk);
    cnt++;
    check(!usAck, "R4 ack one cycle wide", usAck, 0);
    if (holdCycles == 0)
      check(cnt == (v.comb ? 3 : 4), "R6 upstream strobe width", cnt, v.comb ? 3 : 4);
    usStb = 1'b0;
    if (!keepCyc) usCyc = 1'b0;
    if (v.we)
      check(recAdr == v.adr && recSel == v.sel && recDat == v.wdat,
            "R1 write reached target", recDat, v.wdat);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!dsCyc && !dsStb && !usAck, "R8 reset state", {dsCyc, dsStb, usAck}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Vector table
    for (int k = 0; k < 6; k++) access(VECS[k], 0, 0);

    // R7: master holds strobe after completion, then a block-style second beat
    access('{1'b0, 1'b0, 32'h0000_3000, 4'hF, 32'h0}, 5, 1);
    access('{1'b1, 1'b0, 32'h0000_3004, 4'hF, 32'h0}, 3, 0);

    // R9: cycle dropped while waiting for an acknowledge
    noAck = 1'b1;
    combMode = 1'b0;
    @(negedge clk);
    usCyc = 1'b1; usStb = 1'b1; usAdr = 32'h0000_4000; usWe = 1'b0;
    repeat (3) @(negedge clk);
    check(dsStb, "R9 access pending", dsStb, 1);
    usCyc = 1'b0; usStb = 1'b0;
    @(negedge clk);
    check(!dsStb && !dsCyc, "R9 strobe and cycle dropped", {dsStb, dsCyc}, 0);
    begin
      bit sawAck = 0;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (usAck || dsStb) sawAck = 1;
      end
      check(!sawAck, "R9 no ack after abort", sawAck, 0);
    end
    noAck = 1'b0;

    // R8: reset during an access
    @(negedge clk);
    usCyc = 1'b1; usStb = 1'b1; usAdr = 32'h0000_5000;
    @(negedge clk);
    check(dsStb, "R8 access started before reset", dsStb, 1);
    rst = 1'b1;
    @(negedge clk);
    check(!dsCyc && !dsStb && !usAck, "R8 reset mid-access", {dsCyc, dsStb, usAck}, 0);
    usCyc = 1'b0; usStb = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Recovery after reset
    access('{1'b0, 1'b0, 32'h0000_6000, 4'hF, 32'h0}, 0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule